// File: doc/BRIEF.md
# Embedded Controller Host Port

This block is the device end of a byte-wide host interface that reaches a 256-entry internal register space indirectly. The host sees two locations selected by one select bit: the data port (select 0) and a combined port (select 1) that returns a status byte when read and takes a command byte when written. Every internal access is a short conversation. The host sends a command byte, then one or two data bytes, and waits on two handshake flags between steps. The input-buffer-full flag (IBF) says the block has not yet taken the last byte. The output-buffer-full flag (OBF) says a byte is waiting for the host.

Inside, a sequencer takes each host byte after a fixed number of cycles and decodes it. It drives a simple synchronous register bus: a one-cycle read strobe, or a one-cycle write strobe with address and data. The register space answers the read strobe in the same cycle. A read result goes into a holding register that the host collects through the data port. A burst flag is kept for host software and shows in the status byte.

Top module: `ecp_host_port`

## Requirements
- R1: After reset the status byte reads 0x00, OBF and IBF are clear, the burst flag is off, and neither register bus strobe is active.
- R2: Any host write sets IBF (status bit 1) on the next cycle. Status bit 3 then reads 1 if the byte went to the command port (select 1) and 0 if it went to the data port (select 0). Status bits 2, 5, 6 and 7 always read 0.
- R3: IBF stays set for exactly CONSUME_CYCLES clock cycles after the write edge and then clears. A new host write restarts the count.
- R4: Command 0x80 followed by one address byte produces one register read strobe at that address. The value read then appears on the data port with OBF (status bit 0) set.
- R5: A host read of the data port clears OBF on the next cycle.
- R6: Command 0x81 followed by an address byte and then a data byte produces exactly one register write strobe carrying that address and data. Read and write strobes are never active together.
- R7: Command 0x82 sets the burst flag (status bit 4) and command 0x83 clears it. No other byte changes it.
- R8: Command 0x84 (query) reads the register at address QUERY_ADDR, default 0xFF, and presents it on the data port with OBF set.
- R9: A command byte other than 0x80 to 0x84 is ignored and returns the sequencer to idle. A data byte that follows it causes no register access, sets no OBF and leaves the burst flag unchanged.
- R10: A command byte that arrives in the middle of a read or write sequence abandons that sequence. No write strobe is issued for the abandoned sequence, and the new command runs normally.
- R11: A data byte written while the sequencer is idle causes no register access and no OBF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe, one cycle per byte |
| host_rd | input | 1 | Host read strobe, one cycle per byte |
| host_sel | input | 1 | 0 selects the data port, 1 the status/command port |
| host_wdata | input | 8 | Byte written by the host |
| host_rdata | output | 8 | Status byte (select 1) or output data byte (select 0) |
| reg_addr | output | 8 | Register bus address |
| reg_wdata | output | 8 | Register bus write data |
| reg_we | output | 1 | Register bus write strobe |
| reg_re | output | 1 | Register bus read strobe |
| reg_rdata | input | 8 | Register bus read data, valid in the cycle of reg_re |

## Verification
The bench measures IBF cycle by cycle after a write. A design that clears it one cycle early or late would let the host overrun a byte that has not been taken, or would stall the host. The bench interleaves a new command into a half-finished write sequence. A sequencer that does not restart would then write the wrong register or treat the new address as write data. It also sends an unknown code and stray data bytes while idle; a decoder with a loose default would make phantom bus accesses or raise OBF. Read, query and write results are checked against a bench model of the register space. The bench also confirms that OBF drops after the data-port read, so a design that leaves it set would make the host pick up stale data.

// File: rtl/ecp_pkg.sv
package ecp_pkg;

    localparam int BYTE_W = 8;

    // command codes decoded by the sequencer
    localparam logic [7:0] OP_READ      = 8'h80;
    localparam logic [7:0] OP_WRITE     = 8'h81;
    localparam logic [7:0] OP_BURST_ON  = 8'h82;
    localparam logic [7:0] OP_BURST_OFF = 8'h83;
    localparam logic [7:0] OP_QUERY     = 8'h84;

    // status bit positions
    localparam int ST_OBF   = 0;
    localparam int ST_IBF   = 1;
    localparam int ST_CMD   = 3;
    localparam int ST_BURST = 4;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_RD_ADDR,
        SQ_WR_ADDR,
        SQ_WR_DATA
    } sq_state_e;

    typedef struct packed {
        logic [BYTE_W-1:0] val;
        logic              is_cmd;
    } host_byte_t;

    function automatic logic [BYTE_W-1:0] pack_status(
        input logic obf,
        input logic ibf,
        input logic cmd,
        input logic burst
    );
        logic [BYTE_W-1:0] s;
        s = '0;
        s[ST_OBF]   = obf;
        s[ST_IBF]   = ibf;
        s[ST_CMD]   = cmd;
        s[ST_BURST] = burst;
        return s;
    endfunction

endpackage

// File: rtl/ecp_hostif.sv
module ecp_hostif
    import ecp_pkg::*;
#(
    parameter int CONSUME_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic              host_sel,
    input  logic [BYTE_W-1:0] host_wdata,
    input  logic              obf_load,
    input  logic [BYTE_W-1:0] obf_data,
    input  logic              burst,
    output logic [BYTE_W-1:0] host_rdata,
    output logic              consume,
    output host_byte_t        in_byte,
    output logic              ibf,
    output logic              obf
);
    localparam int CW = $clog2(CONSUME_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(CONSUME_CYCLES - 1);

    logic [CW-1:0]     cnt_q;
    logic              cmd_flag_q;
    logic [BYTE_W-1:0] out_q;

    // the byte is taken once it has waited the full count
    assign consume = ibf && !host_wr && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            ibf        <= 1'b0;
            cmd_flag_q <= 1'b0;
            cnt_q      <= '0;
            in_byte    <= '0;
        end else if (host_wr) begin
            in_byte    <= '{val: host_wdata, is_cmd: host_sel};
            ibf        <= 1'b1;
            cmd_flag_q <= host_sel;
            cnt_q      <= '0;
        end else if (consume) begin
            ibf <= 1'b0;
        end else if (ibf) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            obf   <= 1'b0;
            out_q <= '0;
        end else if (obf_load) begin
            obf   <= 1'b1;
            out_q <= obf_data;
        end else if (host_rd && !host_sel) begin
            obf <= 1'b0;
        end
    end

    always_comb begin
        if (host_sel) host_rdata = pack_status(obf, ibf, cmd_flag_q, burst);
        else          host_rdata = out_q;
    end

endmodule

// File: rtl/ecp_seq.sv
module ecp_seq
    import ecp_pkg::*;
#(
    parameter logic [7:0] QUERY_ADDR = 8'hFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              consume,
    input  host_byte_t        in_byte,
    input  logic [BYTE_W-1:0] reg_rdata,
    output logic [BYTE_W-1:0] reg_addr,
    output logic [BYTE_W-1:0] reg_wdata,
    output logic              reg_we,
    output logic              reg_re,
    output logic              burst,
    output logic              obf_load,
    output logic [BYTE_W-1:0] obf_data
);
    sq_state_e         st_q;
    logic [BYTE_W-1:0] wr_addr_q;

    // register space answers in the strobe cycle
    assign obf_load = reg_re;
    assign obf_data = reg_rdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= SQ_IDLE;
            wr_addr_q <= '0;
            reg_addr  <= '0;
            reg_wdata <= '0;
            reg_we    <= 1'b0;
            reg_re    <= 1'b0;
            burst     <= 1'b0;
        end else begin
            reg_we <= 1'b0;
            reg_re <= 1'b0;
            if (consume) begin
                if (in_byte.is_cmd) begin
                    // any command restarts the sequence
                    st_q <= SQ_IDLE;
                    case (in_byte.val)
                        OP_READ:      st_q  <= SQ_RD_ADDR;
                        OP_WRITE:     st_q  <= SQ_WR_ADDR;
                        OP_BURST_ON:  burst <= 1'b1;
                        OP_BURST_OFF: burst <= 1'b0;
                        OP_QUERY: begin
                            reg_re   <= 1'b1;
                            reg_addr <= QUERY_ADDR;
                        end
                        default: ;
                    endcase
                end else begin
                    case (st_q)
                        SQ_RD_ADDR: begin
                            reg_re   <= 1'b1;
                            reg_addr <= in_byte.val;
                            st_q     <= SQ_IDLE;
                        end
                        SQ_WR_ADDR: begin
                            wr_addr_q <= in_byte.val;
                            st_q      <= SQ_WR_DATA;
                        end
                        SQ_WR_DATA: begin
                            reg_we    <= 1'b1;
                            reg_addr  <= wr_addr_q;
                            reg_wdata <= in_byte.val;
                            st_q      <= SQ_IDLE;
                        end
                        default: st_q <= SQ_IDLE;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/ecp_host_port.sv
module ecp_host_port
    import ecp_pkg::*;
#(
    parameter int         CONSUME_CYCLES = 4,
    parameter logic [7:0] QUERY_ADDR     = 8'hFF
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       host_wr,
    input  logic       host_rd,
    input  logic       host_sel,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    output logic [7:0] reg_addr,
    output logic [7:0] reg_wdata,
    output logic       reg_we,
    output logic       reg_re,
    input  logic [7:0] reg_rdata
);
    logic              consume_w;
    host_byte_t        in_byte_w;
    logic              ibf_w;
    logic              obf_w;
    logic              obf_load_w;
    logic [BYTE_W-1:0] obf_data_w;
    logic              burst_w;

    ecp_hostif #(.CONSUME_CYCLES(CONSUME_CYCLES)) u_hostif (
        .clk        (clk),
        .rst        (rst),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_sel   (host_sel),
        .host_wdata (host_wdata),
        .obf_load   (obf_load_w),
        .obf_data   (obf_data_w),
        .burst      (burst_w),
        .host_rdata (host_rdata),
        .consume    (consume_w),
        .in_byte    (in_byte_w),
        .ibf        (ibf_w),
        .obf        (obf_w)
    );

    ecp_seq #(.QUERY_ADDR(QUERY_ADDR)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .consume   (consume_w),
        .in_byte   (in_byte_w),
        .reg_rdata (reg_rdata),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .reg_re    (reg_re),
        .burst     (burst_w),
        .obf_load  (obf_load_w),
        .obf_data  (obf_data_w)
    );

endmodule

// File: rtl/ecp_host_port_chk.sv
module ecp_host_port_chk (
    input logic clk,
    input logic rst,
    input logic host_wr,
    input logic host_rd,
    input logic host_sel,
    input logic ibf,
    input logic obf,
    input logic obf_load,
    input logic consume,
    input logic burst,
    input logic reg_we,
    input logic reg_re
);
    assert_ibf_set_R2: assert property (@(posedge clk) disable iff (rst)
        host_wr |=> ibf);

    assert_ibf_clear_R3: assert property (@(posedge clk) disable iff (rst)
        (consume && !host_wr) |=> !ibf);

    assert_obf_after_read_R4: assert property (@(posedge clk) disable iff (rst)
        reg_re |=> obf);

    assert_obf_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (host_rd && !host_sel && !obf_load) |=> !obf);

    assert_bus_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({reg_we, reg_re}));

    assert_burst_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !consume |=> $stable(burst));

    assert_access_needs_byte_R11: assert property (@(posedge clk) disable iff (rst)
        (reg_we || reg_re) |-> $past(consume));

endmodule

bind ecp_host_port ecp_host_port_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .host_wr  (host_wr),
    .host_rd  (host_rd),
    .host_sel (host_sel),
    .ibf      (ibf_w),
    .obf      (obf_w),
    .obf_load (obf_load_w),
    .consume  (consume_w),
    .burst    (burst_w),
    .reg_we   (reg_we),
    .reg_re   (reg_re)
);

// File: tb/ecp_host_port_test.sv
module ecp_host_port_test;
    localparam int         CONSUME = 4;
    localparam logic [7:0] QADDR   = 8'hFF;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_wr = 1'b0;
    logic       host_rd = 1'b0;
    logic       host_sel = 1'b1;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;
    logic [7:0] reg_addr;
    logic [7:0] reg_wdata;
    logic       reg_we;
    logic       reg_re;
    logic [7:0] reg_rdata;

    logic [7:0] mem [256];
    logic [15:0] exp_wr_q[$];
    int checks = 0;
    int errors = 0;
    int n_wr = 0;
    int n_rd = 0;

    always #5 clk = ~clk;

    assign reg_rdata = mem[reg_addr];

    ecp_host_port #(.CONSUME_CYCLES(CONSUME), .QUERY_ADDR(QADDR)) uut (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
        .host_sel(host_sel), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
        .reg_re(reg_re), .reg_rdata(reg_rdata)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: register bus scoreboard
    always @(negedge clk) begin
        if (!rst && reg_we) begin
            n_wr++;
            checks++;
            if (exp_wr_q.size() == 0) begin
                errors++;
                $display("FAIL R6 actual=%0h expected=none", {reg_addr, reg_wdata});
            end else begin
                logic [15:0] e;
                e = exp_wr_q.pop_front();
                if (e != {reg_addr, reg_wdata}) begin
                    errors++;
                    $display("FAIL R6 actual=%0h expected=%0h", {reg_addr, reg_wdata}, e);
                end
            end
            mem[reg_addr] = reg_wdata;
        end
        if (!rst && reg_re) n_rd++;
    end

    task automatic read_status(output logic [7:0] s);
        host_sel = 1'b1;
        #1 s = host_rdata;
    endtask

    task automatic host_write(input logic sel, input logic [7:0] v);
        @(negedge clk);
        host_sel = sel; host_wdata = v; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic wait_ibf_clear();
        logic [7:0] s;
        read_status(s);
        for (int i = 0; i < 50 && s[1]; i++) begin
            @(negedge clk);
            read_status(s);
        end
    endtask

    task automatic send(input logic sel, input logic [7:0] v);
        wait_ibf_clear();
        host_write(sel, v);
    endtask

    task automatic collect(input string req, input logic [7:0] expv);
        logic [7:0] s;
        logic [7:0] d;
        wait_ibf_clear();
        read_status(s);
        for (int i = 0; i < 50 && !s[0]; i++) begin
            @(negedge clk);
            read_status(s);
        end
        check(s[0], req, s, 1);
        @(negedge clk);
        host_sel = 1'b0; host_rd = 1'b1;
        #1 d = host_rdata;
        check(d == expv, req, d, expv);
        @(negedge clk);
        host_rd = 1'b0;
        read_status(s);
        check(s[0] == 1'b0, "R5", s[0], 0);
    endtask

    task automatic ec_write(input logic [7:0] a, input logic [7:0] v);
        exp_wr_q.push_back({a, v});
        send(1'b1, 8'h81);
        send(1'b0, a);
        send(1'b0, v);
        wait_ibf_clear();
        repeat (2) @(negedge clk);
    endtask

    task automatic ec_read(input logic [7:0] a, input string req);
        logic [7:0] e;
        send(1'b1, 8'h80);
        send(1'b0, a);
        wait_ibf_clear();
        @(negedge clk);
        e = mem[a];
        collect(req, e);
    endtask

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] s;
        int wr0, rd0;
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3) ^ 8'h5A;
        mem[QADDR] = 8'hC3;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        read_status(s);
        check(s == 8'h00, "R1", s, 0);
        check(!reg_we && !reg_re, "R1", {reg_we, reg_re}, 0);

        // R2/R3: command byte, exact IBF window; R7 burst on
        host_write(1'b1, 8'h82);
        read_status(s);
        check(s[1] && s[3], "R2", s, 8'h0A);
        check((s & 8'hE4) == 0, "R2", s & 8'hE4, 0);
        for (int k = 1; k < CONSUME; k++) begin
            @(negedge clk);
            read_status(s);
            check(s[1], "R3", s[1], 1);
        end
        @(negedge clk);
        read_status(s);
        check(!s[1], "R3", s[1], 0);
        check(s[4], "R7", s[4], 1);

        // R2/R11: data byte while idle
        wr0 = n_wr; rd0 = n_rd;
        host_write(1'b0, 8'h3C);
        read_status(s);
        check(s[1] && !s[3], "R2", s, 8'h12);
        wait_ibf_clear();
        repeat (3) @(negedge clk);
        read_status(s);
        check(!s[0] && n_wr == wr0 && n_rd == rd0, "R11", {s[0], 8'(n_wr - wr0)}, 0);

        // R7: burst off
        send(1'b1, 8'h83);
        wait_ibf_clear();
        read_status(s);
        check(!s[4], "R7", s[4], 0);

        // R6: writes
        ec_write(8'h10, 8'hA5);
        ec_write(8'h00, 8'h11);
        ec_write(8'hFE, 8'h77);

        // R4/R5: reads
        ec_read(8'h10, "R4");
        ec_read(8'hFE, "R4");
        ec_read(8'h33, "R4");

        // R8: query
        send(1'b1, 8'h84);
        collect("R8", 8'hC3);

        // R9: unknown command, stray data
        wr0 = n_wr; rd0 = n_rd;
        send(1'b1, 8'h85);
        send(1'b0, 8'h20);
        send(1'b0, 8'h21);
        wait_ibf_clear();
        repeat (3) @(negedge clk);
        read_status(s);
        check(!s[0] && !s[4] && n_wr == wr0 && n_rd == rd0, "R9", s, 0);
        ec_read(8'h20, "R9");

        // R10: write aborted by read command
        wr0 = n_wr;
        send(1'b1, 8'h81);
        send(1'b0, 8'h40);
        ec_read(8'h41, "R10");
        check(n_wr == wr0, "R10", n_wr - wr0, 0);

        // R10: write aborted by burst command before data
        send(1'b1, 8'h81);
        send(1'b0, 8'h50);
        send(1'b1, 8'h82);
        send(1'b0, 8'h99);
        wait_ibf_clear();
        repeat (3) @(negedge clk);
        read_status(s);
        check(n_wr == wr0 && s[4] && !s[0], "R10", {s, 8'(n_wr - wr0)}, 16'h1000);
        send(1'b1, 8'h83);
        wait_ibf_clear();

        check(exp_wr_q.size() == 0, "R6", exp_wr_q.size(), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule